// File: doc/BRIEF.md
# Descriptor-Driven Transmit DMA Engine

This engine feeds an Ethernet MAC from a chain of transmit descriptors kept in shared memory. Software programs the address of the first descriptor and a size code, then writes 1 to a start bit. From there the engine runs on its own. For each descriptor it reads three words: a control word, a length word and a buffer pointer. It streams the buffer out as 32-bit words, writes a completion status back into the control word, and moves on to the next descriptor, which sits directly after the current one.

A frame can come from one buffer or from several consecutive buffers. Two position bits in the control word say whether a buffer opens a frame, closes a frame, lies inside a frame or holds a whole frame. The stream marks the final word of each frame, and during that word it reports the exact byte length of the frame. The engine stops at the first descriptor it does not own. An end-of-list flag sends it back to the start address. It owns a single memory master with one access in flight, so descriptor reads, buffer reads and status writes take turns on that port.

Top module: `txdesc_dma`

## Requirements
- R1: During reset and right after it, `mem_req`, `tx_valid` and `tx_busy` are all 0.
- R2: Register address 0 holds the list start address. Register address 1 bits 1:0 hold the size code. A write of 1 to bit 0 at register address 2 while `tx_busy` is 0 sets `tx_busy`, and in the next cycle the engine issues a read of the list start address.
- R3: A descriptor is word 0 (control), word 1 (buffer byte length in bits 31:16) and word 2 (buffer start address), at byte offsets 0, 4 and 8. The buffer is sent as ceil(length/4) consecutive words, in address order, starting at the buffer address.
- R4: The size code sets the distance from one descriptor to the next: 0 gives 16 bytes, 1 gives 32 bytes, 2 gives 64 bytes and 3 gives 16 bytes.
- R5: Control bits 29:28 give the buffer's position in its frame: 11 means a whole frame, 10 a first buffer, 00 a middle buffer and 01 a last buffer. `tx_last` is 1 only on the final word of a buffer whose bit 28 is set.
- R6: While `tx_last` is 1, `frame_bytes` equals the sum of the byte lengths of all buffers in the frame. The sum begins at a buffer whose bit 29 is set.
- R7: When a buffer has been fully sent, the engine writes the control word back to its descriptor with bit 31 (valid) and bit 27 (error) cleared and every other bit unchanged.
- R8: When a fetched control word has bit 31 clear, the engine clears `tx_busy`, sends nothing from that descriptor and leaves that descriptor unchanged in memory.
- R9: After finishing a descriptor whose control bit 30 is set, the engine reads its next descriptor from the list start address.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data`, `tx_last` and `frame_bytes` stay the same into the next cycle.
- R11: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay the same into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 start address, 1 size code, 2 start bit |
| reg_wdata | input | 32 | Register write data |
| tx_busy | output | 1 | Start bit; cleared when an unowned descriptor is fetched |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a status write, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 32 | Stream data word |
| tx_valid | output | 1 | Stream word valid |
| tx_ready | input | 1 | Stream sink accepts the word |
| tx_last | output | 1 | Final word of a frame |
| frame_bytes | output | LEN_W | Byte length of the frame, meaningful while `tx_last` is 1 |

## Verification
The memory model acknowledges each access one cycle after it sees the request, so every descriptor word, buffer word and status write costs two cycles. The start write shows up as a read of the list start address at the first falling edge after the write strobe is removed. A stream word counts as transferred at the rising edge where `tx_valid` and `tx_ready` are both 1. The scoreboard therefore samples `tx_data`, `tx_last` and `frame_bytes` at the falling edge before that rising edge. Status words and untouched descriptors are read back from the model only after `tx_busy` has fallen, when no write can still be pending.

// File: rtl/txdesc_dma.sv
module txdesc_dma #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              tx_busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [31:0]       tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic [LEN_W-1:0]  frame_bytes
);
  localparam int WC_W = LEN_W - 1;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_RD2, S_FETCH, S_SEND, S_WB} st_t;

  st_t               st;
  logic [ADDR_W-1:0] base, cur, bptr, step;
  logic [1:0]        dsz;
  logic [31:0]       ctl, data;
  logic [LEN_W-1:0]  len;
  logic [WC_W-1:0]   wleft;
  logic [LEN_W:0]    lr;
  logic              busy;

  assign lr = {1'b0, len} + (LEN_W+1)'(3);

  always_comb begin
    case (dsz)
      2'd1:    step = ADDR_W'(32);
      2'd2:    step = ADDR_W'(64);
      default: step = ADDR_W'(16);
    endcase
  end

  assign tx_busy     = busy;
  assign mem_req     = (st == S_RD0) || (st == S_RD1) || (st == S_RD2) || (st == S_FETCH) || (st == S_WB);
  assign mem_we      = (st == S_WB);
  assign mem_wdata   = ctl & ~32'h8800_0000;
  assign tx_valid    = (st == S_SEND);
  assign tx_data     = data;
  assign tx_last     = (st == S_SEND) && (wleft == WC_W'(1)) && ctl[28];
  assign frame_bytes = len;

  always_comb begin
    case (st)
      S_RD1:   mem_addr = cur + ADDR_W'(4);
      S_RD2:   mem_addr = cur + ADDR_W'(8);
      S_FETCH: mem_addr = bptr;
      default: mem_addr = cur;
    endcase
  end

  logic [LEN_W-1:0] fsum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      busy  <= 1'b0;
      base  <= '0;
      dsz   <= '0;
      cur   <= '0;
      bptr  <= '0;
      ctl   <= '0;
      data  <= '0;
      len   <= '0;
      fsum  <= '0;
      wleft <= '0;
    end else begin
      if (reg_we && reg_addr == 2'd0) base <= ADDR_W'(reg_wdata);
      if (reg_we && reg_addr == 2'd1) dsz <= reg_wdata[1:0];
      case (st)
        S_IDLE:
          if (reg_we && reg_addr == 2'd2 && reg_wdata[0] && !busy) begin
            busy <= 1'b1;
            cur  <= base;
            fsum <= '0;
            st   <= S_RD0;
          end
        S_RD0:
          if (mem_ack) begin
            ctl <= mem_rdata;
            if (!mem_rdata[31]) begin
              busy <= 1'b0;
              st   <= S_IDLE;
            end else begin
              st <= S_RD1;
            end
          end
        S_RD1:
          if (mem_ack) begin
            len  <= mem_rdata[31:16];
            fsum <= (ctl[29] ? '0 : fsum) + mem_rdata[31:16];
            st   <= S_RD2;
          end
        S_RD2:
          if (mem_ack) begin
            bptr  <= ADDR_W'(mem_rdata);
            wleft <= lr[LEN_W:2];
            len   <= fsum;
            st    <= (lr[LEN_W:2] == '0) ? S_WB : S_FETCH;
          end
        S_FETCH:
          if (mem_ack) begin
            data <= mem_rdata;
            st   <= S_SEND;
          end
        S_SEND:
          if (tx_ready) begin
            bptr  <= bptr + ADDR_W'(4);
            wleft <= wleft - WC_W'(1);
            st    <= (wleft == WC_W'(1)) ? S_WB : S_FETCH;
          end
        S_WB:
          if (mem_ack) begin
            cur <= ctl[30] ? base : cur + step;
            st  <= S_RD0;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic [31:0]       tx_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_last,
  input logic [LEN_W-1:0]  frame_bytes
);
  a_r10_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(frame_bytes));

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  a_r7_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31] && !mem_wdata[27]);

  a_r5_last_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r8_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !mem_req && !tx_valid);
endmodule

bind txdesc_dma txdesc_dma_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/txdesc_dma_tb.sv
module txdesc_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        tx_busy, mem_req, mem_we, mem_ack, tx_valid, tx_ready, tx_last;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, tx_data;
  logic [15:0] frame_bytes;

  always #10 clk = ~clk;

  txdesc_dma u_dut (.*);

  logic [31:0] mem [0:1023];
  logic        hw_en = 1'b0;
  logic [9:0]  hw_idx = '0;
  logic [31:0] hw_val = '0;
  logic [7:0]  lf;

  assign mem_rdata = mem[mem_addr[11:2]];
  assign tx_ready  = lf[0] | lf[1];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lf      <= 8'h5A;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      lf      <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
    else if (hw_en) mem[hw_idx] <= hw_val;
  end

  int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
  logic [48:0] expq [$];
  int facc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", (n_chk + m_chk) - (n_fail + m_fail), n_chk + m_chk);
    $finish;
  endtask

  task automatic poke(input int addr, input logic [31:0] v);
    @(negedge clk);
    hw_en = 1'b1; hw_idx = addr[11:2]; hw_val = v;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // driver: lays out one descriptor and its buffer, queues the expected beats
  task automatic add_desc(input int da, input logic [31:0] ctrl, input int len, input int ba, input bit exp);
    int nw;
    poke(da, ctrl);
    poke(da + 4, {len[15:0], 16'hBEEF});
    poke(da + 8, ba);
    poke(da + 12, 32'hDEAD_0000 | da);
    nw = (len + 3) / 4;
    if (exp && ctrl[29]) facc = 0;
    if (exp) facc += len;
    for (int i = 0; i < nw; i++) begin
      logic [31:0] w;
      logic        lst;
      w   = 32'hA000_0000 | (ba << 8) | i;
      lst = ctrl[28] && (i == nw - 1);
      poke(ba + 4 * i, w);
      if (exp) expq.push_back({w, lst, lst ? facc[15:0] : 16'h0});
    end
  endtask

  task automatic run(input int base, input logic [1:0] sz, input string tag);
    wreg(2'd0, base);
    wreg(2'd1, {30'd0, sz});
    wreg(2'd2, 32'd1);
    chk(mem_req && !mem_we && mem_addr == base, "R2 first read at list start", {31'd0, mem_req, mem_addr}, {32'd1, base[31:0]});
    for (int k = 0; k < 4000 && tx_busy; k++) @(negedge clk);
    chk(!tx_busy, {tag, " R8 engine stopped"}, {63'd0, tx_busy}, 64'd0);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, {tag, " R3 R4 all expected words sent"}, expq.size(), 64'd0);
  endtask

  task automatic monitor();
    logic        stall = 1'b0, mpend = 1'b0;
    logic [48:0] held = '0;
    logic [31:0] maddr = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        logic [48:0] act;
        act = {tx_data, tx_last, tx_last ? frame_bytes : 16'h0};
        if (stall) begin
          m_chk++;
          if (!(tx_valid && act == held)) begin
            m_fail++;
            $display("FAIL R10 stalled word changed actual %h expected %h", act, held);
          end
        end
        if (mpend) begin
          m_chk++;
          if (!(mem_req && mem_addr == maddr)) begin
            m_fail++;
            $display("FAIL R11 request dropped actual %h expected %h", mem_addr, maddr);
          end
        end
        stall = tx_valid && !tx_ready;
        held  = act;
        mpend = mem_req && !mem_ack;
        maddr = mem_addr;
        if (tx_valid && tx_ready) begin
          m_chk++;
          if (expq.size() == 0) begin
            m_fail++;
            $display("FAIL R3 R9 unexpected word actual %h expected none", act);
          end else begin
            logic [48:0] e;
            e = expq.pop_front();
            if (act != e) begin
              m_fail++;
              $display("FAIL R3 R5 R6 word actual %h expected %h", act, e);
            end
          end
        end
      end
    end
  endtask

  initial begin
    fork
      monitor();
      begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual running expected done");
        finish_up();
      end
    join_none

    repeat (3) @(negedge clk);
    chk(!mem_req && !tx_valid && !tx_busy, "R1 reset outputs", {61'd0, mem_req, tx_valid, tx_busy}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !tx_valid && !tx_busy, "R1 after reset", {61'd0, mem_req, tx_valid, tx_busy}, 64'd0);

    // whole frame in one buffer, 16-byte descriptors
    add_desc(32'h100, 32'hB800_005A, 10, 32'h800, 1);
    add_desc(32'h110, 32'h3000_0000, 8, 32'h880, 0);
    run(32'h100, 2'd0, "A");
    chk(mem[64] == 32'h3000_005A, "R7 status of whole buffer", mem[64], 32'h3000_005A);
    chk(mem[68] == 32'h3000_0000, "R8 unowned descriptor untouched", mem[68], 32'h3000_0000);

    // three-buffer frame, 32-byte descriptors
    add_desc(32'h200, 32'hA800_0001, 4, 32'h840, 1);
    add_desc(32'h220, 32'h8000_0002, 8, 32'h860, 1);
    add_desc(32'h240, 32'h9000_0003, 5, 32'h880, 1);
    add_desc(32'h260, 32'h1000_0000, 4, 32'h8C0, 0);
    run(32'h200, 2'd1, "B");
    chk(mem[128] == 32'h2000_0001, "R7 status of first buffer", mem[128], 32'h2000_0001);
    chk(mem[136] == 32'h0000_0002, "R5 R7 status of middle buffer", mem[136], 32'h0000_0002);
    chk(mem[144] == 32'h1000_0003, "R7 status of last buffer", mem[144], 32'h1000_0003);

    // two whole frames, 64-byte descriptors
    add_desc(32'h300, 32'hB000_0000, 7, 32'h900, 1);
    add_desc(32'h340, 32'hB000_0000, 16, 32'h940, 1);
    add_desc(32'h380, 32'h3000_0000, 4, 32'h980, 0);
    run(32'h300, 2'd2, "C");
    chk(mem[208] == 32'h3000_0000, "R4 second 64-byte descriptor completed", mem[208], 32'h3000_0000);

    // end-of-list wrap, size code 3 gives 16 bytes
    add_desc(32'h500, 32'hF000_0000, 3, 32'hA00, 1);
    add_desc(32'h510, 32'hB000_0000, 4, 32'hA40, 0);
    run(32'h500, 2'd3, "D");
    chk(mem[320] == 32'h7000_0000, "R9 R7 end-of-list status", mem[320], 32'h7000_0000);
    chk(mem[324] == 32'hB000_0000, "R9 descriptor after end-of-list skipped", mem[324], 32'hB000_0000);

    finish_up();
  end
endmodule